// File: doc/BRIEF.md
# Synchronous Serial Transceiver with Frame Parity

This block is a full-duplex synchronous serial port. Each frame carries eight data bits, most significant bit first. An optional parity bit can follow the data. The unit either generates the shift clock itself (master role) or follows a clock supplied from outside (slave role). In both roles the outgoing bit changes on the falling clock edge and the incoming bit is sampled on the rising edge. In master mode the clock idles low.

Software writes a control register to set the behaviour. This register selects the role, enables the unit and configures parity. Transmit parity and receive parity have separate enables but share one even/odd selection. A receive parity mismatch can be ignored or latched into a sticky error flag.

Writing the data register starts a frame. The received byte is presented with a one-cycle valid pulse when the frame ends.

Register map, selected by `bus_addr`:
- Address 0 is control, read/write:
  - bit0: master
  - bit1: enable
  - bit2: transmit parity
  - bit3: receive parity
  - bit4: odd parity
  - bit5: error check
- Address 1: a write loads transmit data, and a read returns the last received byte.
- Address 2 is status:
  - bit0: busy, read only.
  - bit1: parity error; writing 1 to this bit clears it.

Top module: `ssp_parity_top`

## Requirements
- R1: After reset, the port is idle and in the slave role: busy, parity error, enabled, `sclk_o` and `sdo_o` are all 0, `slave_sel_o` is 1, and the control register reads 0.
- R2: Control bit0 selects the role. At 1, the block drives `sclk_oe_o` high and generates the clock. At 0, it shifts on `sclk_i`. `slave_sel_o` is always the inverse of bit0.
- R3: While control bit1 (enable) is 0, a write to address 1 starts nothing: busy stays 0 and `sclk_o` stays low. `enabled_o` shows bit1.
- R4: A control write made while busy is held back, so enable stays 1 for the rest of the frame. The held-back value takes effect in the cycle the frame ends.
- R5: In master mode, a frame of N bits sends data MSB first with an `sclk_o` period of CLK_DIV system clocks, starting low. Busy is high for exactly N*CLK_DIV cycles after the start write is sampled.
- R6: When control bit2 is 1, a parity bit is sent after the eight data bits.
- R7: When either parity enable (bit2 or bit3) is 1, the frame has 9 clock periods, otherwise 8. If only bit3 is set, `sdo_o` is 0 during the ninth period.
- R8: With control bit4 at 0 (even), the parity bit is the XOR of the data bits. With bit4 at 1 (odd), it is the inverse of that XOR. The same rule applies to transmit and receive.
- R9: A received parity bit that does not match sets the parity error flag, but only when bit3 and bit5 are both 1. The flag stays set until it is cleared.
- R10: Writing 1 to status bit1 clears the parity error flag. If a new error is detected in the same cycle as the clear, the flag stays 1.
- R11: In slave mode, `sclk_i` passes through a synchronizer. The block shifts on its rising and falling edges, and the frame ends on the falling edge after the last bit.
- R12: At the end of a frame, busy drops, `rx_valid_o` pulses for one cycle and `rx_data_o` holds the byte received MSB first. The same byte reads back at address 1.
- R13: A write to address 1 while busy is ignored, and the frame in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| busy_o | output | 1 | Frame in progress |
| perr_o | output | 1 | Sticky receive parity error |
| rx_valid_o | output | 1 | One-cycle pulse when a frame ends |
| rx_data_o | output | 8 | Last received byte |
| enabled_o | output | 1 | Enable bit |
| slave_sel_o | output | 1 | Inverse of the master bit |
| sclk_i | input | 1 | External shift clock (slave) |
| sclk_o | output | 1 | Generated shift clock (master) |
| sclk_oe_o | output | 1 | Output enable for `sclk_o` |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |

## Verification
Detection of a parity error and a software write-one-to-clear of the flag can fall in the same clock edge. The frame end, which sets the flag, is the edge exactly N*CLK_DIV cycles after the start write. The bench provokes the collision by starting a master frame with a wrong received parity bit and timing the clear write so that it is sampled on that edge. It judges the outcome by requiring the flag to read 1 afterwards, then checks that a later clear alone empties it. A second collision is a control write landing mid-frame; here the bench checks that enable holds until the frame ends.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_DATA = 2'd1;
  localparam logic [1:0] ADDR_STAT = 2'd2;

  // control word, bit0 = master ... bit5 = parity error check
  typedef struct packed {
    logic perr_en;
    logic odd;
    logic rx_par;
    logic tx_par;
    logic en;
    logic master;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);
endpackage

// File: rtl/ssp_regs.sv
module ssp_regs
  import ssp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        addr,
  input  logic [CTRL_W-1:0] wdata,
  input  logic              busy,
  input  logic              done,
  input  logic              perr_set,
  input  logic [DATA_W-1:0] rx_data,
  output ctrl_t             ctrl,
  output logic              perr,
  output logic              tx_start,
  output logic [DATA_W-1:0] rdata
);
  ctrl_t ctrl_q, ctrl_d, pend_q, pend_d;
  logic  pend_v_q, pend_v_d;
  logic  perr_q, perr_d;
  logic  wr_ctrl, wr_data, wr_stat;

  assign wr_ctrl = we && (addr == ADDR_CTRL);
  assign wr_data = we && (addr == ADDR_DATA);
  assign wr_stat = we && (addr == ADDR_STAT);

  always_comb begin
    ctrl_d   = ctrl_q;
    pend_d   = pend_q;
    pend_v_d = pend_v_q;
    if (done) begin
      if (wr_ctrl)       ctrl_d = ctrl_t'(wdata);
      else if (pend_v_q) ctrl_d = pend_q;
      pend_v_d = 1'b0;
    end else if (wr_ctrl) begin
      if (busy) begin
        pend_d   = ctrl_t'(wdata);
        pend_v_d = 1'b1;
      end else begin
        ctrl_d = ctrl_t'(wdata);
      end
    end
  end

  // detection outranks the clear
  always_comb begin
    if (perr_set)                 perr_d = 1'b1;
    else if (wr_stat && wdata[1]) perr_d = 1'b0;
    else                          perr_d = perr_q;
  end

  assign tx_start = wr_data && !busy && ctrl_q.en;

  always_comb begin
    unique case (addr)
      ADDR_CTRL: rdata = DATA_W'(ctrl_q);
      ADDR_DATA: rdata = rx_data;
      ADDR_STAT: rdata = DATA_W'({perr_q, busy});
      default:   rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      pend_q   <= '0;
      pend_v_q <= 1'b0;
      perr_q   <= 1'b0;
    end else begin
      ctrl_q   <= ctrl_d;
      pend_q   <= pend_d;
      pend_v_q <= pend_v_d;
      perr_q   <= perr_d;
    end
  end

  assign ctrl = ctrl_q;
  assign perr = perr_q;
endmodule

// File: rtl/ssp_clkgen.sv
module ssp_clkgen #(
  parameter int CLK_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic master,
  input  logic run,
  input  logic sclk_i,
  output logic sclk_o,
  output logic rise,
  output logic fall
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] CNT_TOP = CW'(HALF - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          sclk_q, sclk_d;
  logic          active, tick;
  logic [SYNC_STAGES:0] sync_q;
  logic          s_now, s_prev;

  // master divider
  assign active = run && master;
  assign tick   = active && (cnt_q == CNT_TOP);

  always_comb begin
    if (!active) begin
      cnt_d  = '0;
      sclk_d = 1'b0;
    end else if (tick) begin
      cnt_d  = '0;
      sclk_d = ~sclk_q;
    end else begin
      cnt_d  = cnt_q + 1'b1;
      sclk_d = sclk_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      sclk_q <= sclk_d;
    end
  end

  // external clock synchronizer, one flop per stage plus an edge history flop
  for (genvar g = 0; g <= SYNC_STAGES; g++) begin : g_sync
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[0] <= 1'b0;
        else        sync_q[0] <= sclk_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[g] <= 1'b0;
        else        sync_q[g] <= sync_q[g-1];
      end
    end
  end

  assign s_now  = sync_q[SYNC_STAGES-1];
  assign s_prev = sync_q[SYNC_STAGES];

  assign rise   = master ? (tick && !sclk_q) : (run && s_now && !s_prev);
  assign fall   = master ? (tick && sclk_q)  : (run && !s_now && s_prev);
  assign sclk_o = sclk_q;
endmodule

// File: rtl/ssp_engine.sv
module ssp_engine #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_par_en,
  input  logic              rx_par_en,
  input  logic              odd,
  input  logic              perr_en,
  input  logic              rise,
  input  logic              fall,
  input  logic              sdi,
  output logic              busy,
  output logic              sdo,
  output logic              done,
  output logic              perr_set,
  output logic              rx_valid,
  output logic [DATA_W-1:0] rx_data
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] N_DATA   = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LAST_NOP = CNT_W'(DATA_W - 1);

  logic              busy_q, busy_d;
  logic [CNT_W-1:0]  bit_q, bit_d;
  logic [DATA_W-1:0] tx_q, tx_d, rx_q, rx_d, rxd_q, rxd_d;
  logic              txp_q, txp_d, rxp_q, rxp_d;
  logic              valid_q;
  logic              in_data, is_last, exp_par;

  assign in_data = bit_q < N_DATA;
  assign is_last = bit_q == ((tx_par_en || rx_par_en) ? N_DATA : LAST_NOP);
  assign done    = busy_q && fall && is_last;
  assign exp_par = (^rx_q) ^ odd;
  assign perr_set = done && rx_par_en && perr_en && (rxp_q != exp_par);

  always_comb begin
    busy_d = busy_q;
    bit_d  = bit_q;
    tx_d   = tx_q;
    txp_d  = txp_q;
    rx_d   = rx_q;
    rxp_d  = rxp_q;
    if (start) begin
      busy_d = 1'b1;
      bit_d  = '0;
      tx_d   = tx_data;
      txp_d  = tx_par_en && ((^tx_data) ^ odd);
    end else if (busy_q) begin
      if (rise) begin
        if (in_data) rx_d  = {rx_q[DATA_W-2:0], sdi};
        else         rxp_d = sdi;
      end
      if (fall) begin
        if (is_last) begin
          busy_d = 1'b0;
          bit_d  = '0;
        end else begin
          bit_d = bit_q + 1'b1;
          tx_d  = {tx_q[DATA_W-2:0], 1'b0};
        end
      end
    end
  end

  assign rxd_d = done ? rx_q : rxd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      bit_q   <= '0;
      tx_q    <= '0;
      txp_q   <= 1'b0;
      rx_q    <= '0;
      rxp_q   <= 1'b0;
      rxd_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      bit_q   <= bit_d;
      tx_q    <= tx_d;
      txp_q   <= txp_d;
      rx_q    <= rx_d;
      rxp_q   <= rxp_d;
      rxd_q   <= rxd_d;
      valid_q <= done;
    end
  end

  assign busy     = busy_q;
  assign sdo      = busy_q && (in_data ? tx_q[DATA_W-1] : txp_q);
  assign rx_valid = valid_q;
  assign rx_data  = rxd_q;
endmodule

// File: rtl/ssp_parity_top.sv
module ssp_parity_top
  import ssp_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CLK_DIV     = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              busy_o,
  output logic              perr_o,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              enabled_o,
  output logic              slave_sel_o,
  input  logic              sclk_i,
  output logic              sclk_o,
  output logic              sclk_oe_o,
  input  logic              sdi_i,
  output logic              sdo_o
);
  logic [1:0] rst_ff;
  logic       rst_int_n;
  ctrl_t      ctrl;
  logic       tx_start, done, perr_set, rise, fall, busy;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_ff <= 2'b00;
    else        rst_ff <= {rst_ff[0], 1'b1};
  end
  assign rst_int_n = rst_ff[1];

  ssp_regs #(.DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .we       (bus_we),
    .addr     (bus_addr),
    .wdata    (bus_wdata[CTRL_W-1:0]),
    .busy     (busy),
    .done     (done),
    .perr_set (perr_set),
    .rx_data  (rx_data_o),
    .ctrl     (ctrl),
    .perr     (perr_o),
    .tx_start (tx_start),
    .rdata    (bus_rdata)
  );

  ssp_clkgen #(.CLK_DIV(CLK_DIV), .SYNC_STAGES(SYNC_STAGES)) u_clk (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .master (ctrl.master),
    .run    (busy),
    .sclk_i (sclk_i),
    .sclk_o (sclk_o),
    .rise   (rise),
    .fall   (fall)
  );

  ssp_engine #(.DATA_W(DATA_W)) u_eng (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (tx_start),
    .tx_data   (bus_wdata),
    .tx_par_en (ctrl.tx_par),
    .rx_par_en (ctrl.rx_par),
    .odd       (ctrl.odd),
    .perr_en   (ctrl.perr_en),
    .rise      (rise),
    .fall      (fall),
    .sdi       (sdi_i),
    .busy      (busy),
    .sdo       (sdo_o),
    .done      (done),
    .perr_set  (perr_set),
    .rx_valid  (rx_valid_o),
    .rx_data   (rx_data_o)
  );

  assign busy_o      = busy;
  assign enabled_o   = ctrl.en;
  assign slave_sel_o = ~ctrl.master;
  assign sclk_oe_o   = ctrl.master;
endmodule

// File: rtl/ssp_parity_chk.sv
module ssp_parity_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [1:0]        bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              busy_o,
  input logic              perr_o,
  input logic              rx_valid_o,
  input logic              enabled_o,
  input logic              sclk_o
);
  // R13 / R5: a frame begins only on a data-register write
  a_r13_start_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> $past(bus_we && bus_addr == 2'd1));

  // R4: enable cannot be observed low during a frame
  a_r4_busy_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> enabled_o);

  // R3: a disabled, idle port stays idle
  a_r3_disabled_stays_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (!enabled_o && !busy_o) |=> !busy_o);

  // R12: the valid pulse follows the end of a frame
  a_r12_valid_at_end: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid_o |-> $fell(busy_o));

  // R5: shift clock rests low between frames
  a_r5_sclk_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !sclk_o);

  // R10: the error flag only drops after a clear write
  a_r10_perr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(perr_o) |-> $past(bus_we && bus_addr == 2'd2 && bus_wdata[1]));
endmodule

bind ssp_parity_top ssp_parity_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_ssp_parity_top.sv
`timescale 1ns/1ps
module tb_ssp_parity_top;
  localparam int DIV = 8;
  localparam int SHALF = 6;

  logic       clk, rst_n, bus_we, sclk_i, sdi_i;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata, rx_data_o;
  logic busy_o, perr_o, rx_valid_o, enabled_o, slave_sel_o, sclk_o, sclk_oe_o, sdo_o;

  int checks = 0, errors = 0, vcnt = 0;

  ssp_parity_top #(.DATA_W(8), .CLK_DIV(DIV), .SYNC_STAGES(2)) dut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(negedge clk) if (rx_valid_o) vcnt++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  function automatic logic [7:0] ctrl_word(input logic m, input logic en, input logic tp,
                                           input logic rp, input logic od, input logic pe);
    return {2'b00, pe, od, rp, tp, en, m};
  endfunction

  // master frame with optional mid-frame control and data writes
  task automatic run_master(input logic tp, input logic rp, input logic od, input logic pe,
                            input logic [7:0] tx, input logic [7:0] rxb, input logic flip,
                            input logic meddle);
    int nb, cyc, v0;
    logic [8:0] obs, exp_tx, rbits;
    logic [7:0] rd;
    nb     = (tp || rp) ? 9 : 8;
    rbits  = {rxb, ((^rxb) ^ od) ^ flip};
    exp_tx = (nb == 9) ? {tx, tp && ((^tx) ^ od)} : {1'b0, tx};
    obs    = '0;
    cyc    = 0;
    v0     = vcnt;
    bus_wr(2'd0, ctrl_word(1, 1, tp, rp, od, pe));
    sdi_i = rxb[7];
    bus_wr(2'd1, tx);
    fork
      begin
        for (int i = 0; i < nb; i++) begin
          while (!sclk_o) begin @(negedge clk); cyc++; end
          obs = {obs[7:0], sdo_o};
          while (sclk_o) begin @(negedge clk); cyc++; end
          if (i + 1 < nb) sdi_i = rbits[7 - i];
        end
      end
      begin
        if (meddle) begin
          repeat (10) @(negedge clk);
          bus_wr(2'd0, ctrl_word(1, 0, tp, rp, od, pe));
          chk("R4 enable held during frame", enabled_o, 1);
          bus_wr(2'd1, ~tx);
        end
      end
    join
    chk("R5 frame length", cyc, nb * DIV);
    chk("R5 R6 R7 R8 transmitted bits", obs, exp_tx);
    chk("R12 busy low at end", busy_o, 0);
    chk("R12 valid pulse", rx_valid_o, 1);
    chk("R12 received byte", rx_data_o, rxb);
    bus_rd(2'd1, rd);
    chk("R12 readback", rd, rxb);
    chk("R9 parity error flag", perr_o, rp && pe && flip);
    @(negedge clk);
    chk("R12 single pulse", vcnt - v0, 1);
    bus_wr(2'd2, 8'h02);
    chk("R10 cleared", perr_o, 0);
  endtask

  task automatic run_slave(input logic tp, input logic rp, input logic od, input logic pe,
                           input logic [7:0] tx, input logic [7:0] rxb, input logic flip);
    int nb, v0;
    logic [8:0] obs, exp_tx, rbits;
    nb     = (tp || rp) ? 9 : 8;
    rbits  = {rxb, ((^rxb) ^ od) ^ flip};
    exp_tx = (nb == 9) ? {tx, tp && ((^tx) ^ od)} : {1'b0, tx};
    obs    = '0;
    v0     = vcnt;
    bus_wr(2'd0, ctrl_word(0, 1, tp, rp, od, pe));
    chk("R2 slave select output", slave_sel_o, 1);
    chk("R2 no clock drive in slave", sclk_oe_o, 0);
    bus_wr(2'd1, tx);
    for (int i = 0; i < nb; i++) begin
      sdi_i = rbits[8 - i];
      repeat (SHALF) @(negedge clk);
      obs = {obs[7:0], sdo_o};
      sclk_i = 1'b1;
      repeat (SHALF) @(negedge clk);
      if (i < nb - 1) chk("R11 busy mid frame", busy_o, 1);
      sclk_i = 1'b0;
    end
    repeat (SHALF) @(negedge clk);
    chk("R11 slave transmitted bits", obs, exp_tx);
    chk("R11 slave frame done", busy_o, 0);
    chk("R11 slave received byte", rx_data_o, rxb);
    chk("R11 slave parity error", perr_o, rp && pe && flip);
    chk("R12 slave single pulse", vcnt - v0, 1);
    bus_wr(2'd2, 8'h02);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    logic [7:0] rd;
    logic [7:0] pats [5];
    pats = '{8'h00, 8'hFF, 8'hA5, 8'h3C, 8'h81};
    rst_n = 1'b0; bus_we = 1'b0; bus_addr = 2'd0; bus_wdata = '0;
    sclk_i = 1'b0; sdi_i = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 busy", busy_o, 0);
    chk("R1 perr", perr_o, 0);
    chk("R1 enabled", enabled_o, 0);
    chk("R1 slave select", slave_sel_o, 1);
    chk("R1 sclk", sclk_o, 0);
    chk("R1 sdo", sdo_o, 0);
    bus_rd(2'd0, rd);
    chk("R1 control reads zero", rd, 0);

    // R3 disabled start is ignored
    bus_wr(2'd0, ctrl_word(1, 0, 1, 1, 0, 1));
    chk("R3 enabled output low", enabled_o, 0);
    chk("R2 master drives clock", sclk_oe_o, 1);
    chk("R2 slave select inverse", slave_sel_o, 0);
    bus_wr(2'd1, 8'h5A);
    repeat (3 * DIV) begin
      @(negedge clk);
      if (busy_o || sclk_o) chk("R3 no activity while disabled", {busy_o, sclk_o}, 0);
    end
    chk("R3 still idle", busy_o, 0);

    // sweep of every parity configuration over several patterns
    for (int c = 0; c < 16; c++)
      for (int p = 0; p < 5; p++)
        for (int f = 0; f < 2; f++)
          run_master(c[0], c[1], c[2], c[3], pats[p], pats[(p + 2) % 5] ^ 8'(c), f[0], 1'b0);

    // R4 R13 mid-frame control and data writes
    run_master(1, 1, 0, 1, 8'hC3, 8'h17, 1'b0, 1'b1);
    chk("R4 enable cleared after frame", enabled_o, 0);
    bus_wr(2'd1, 8'h11);
    @(negedge clk);
    chk("R4 R3 disabled after deferred clear", busy_o, 0);

    // R10 error detection and clear in the same cycle
    bus_wr(2'd0, ctrl_word(1, 1, 0, 1, 1, 1));
    sdi_i = 1'b0;
    bus_wr(2'd1, 8'h00);
    repeat (9 * DIV - 2) @(negedge clk);
    bus_wr(2'd2, 8'h02);
    chk("R10 busy ended at collision", busy_o, 0);
    chk("R10 set wins over clear", perr_o, 1);
    bus_wr(2'd2, 8'h02);
    chk("R10 later clear works", perr_o, 0);

    // slave mode
    for (int c = 0; c < 4; c++) begin
      run_slave(c[0], c[1], c[0], 1'b1, 8'h96 ^ 8'(c), 8'h4B + 8'(c), c[1]);
      run_slave(c[1], c[0], c[1], 1'b1, 8'h0F, 8'hE2, 1'b1);
    end

    repeat (4) @(negedge clk);
    report();
  end
endmodule